// File: doc/BRIEF.md
# Dual-Source Interrupt Priority Encoder

This block combines the interrupt requests of two serial peripherals into one registered request to the CPU. One peripheral is a synchronous (clocked) serial unit and the other is an asynchronous serial unit. Each source has its own programmable priority level. The block selects the more urgent pending source and drives its level on the request lines. It also raises a request strobe while that level is above the CPU's current interrupt mask.

During an interrupt acknowledge cycle, the block checks whether the acknowledged level is its own. It then competes with other modules by comparing its 4-bit arbitration ID against the highest ID they present. If it wins, it returns an 8-bit vector number taken from a programmable base. The least significant bit of that vector identifies the source. The block also returns the vector table offset, which is the vector number doubled.

Top module: `irq_dual_prio`

## Requirements
- R1: After reset, `irq_lvl_o` is 0, `irq_o` is 0 and `ack_valid_o` is 0.
- R2: A source whose programmed level is 0 never contributes a request, even if its request input is high.
- R3: When both sources are enabled and pending at different levels, `irq_lvl_o` shows the higher of the two levels.
- R4: When both sources are pending at the same non-zero level, the synchronous source wins.
- R5: On a won acknowledge, `vec_o` equals `vec_base_i` with bit 0 replaced by the source. Bit 0 is 1 for the synchronous source and 0 for the asynchronous source. `vec_off_o` equals `vec_o` multiplied by two.
- R6: While `arb_id_i` is 0, `irq_lvl_o` and `irq_o` stay 0 and no acknowledge is answered, whatever the sources request.
- R7: `irq_o` is high exactly when `irq_lvl_o` is strictly greater than `cpu_mask_i`.
- R8: `irq_lvl_o` changes on the first rising clock edge after a change of the source inputs, and not before it.
- R9: The block answers an acknowledge only when three conditions all hold. First, `iack_i` is high. Second, `iack_lvl_i` equals the non-zero `irq_lvl_o`. Third, `arb_id_i` is strictly greater than `arb_bus_i`. Otherwise `ack_valid_o`, `vec_o` and `vec_off_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req_i | input | 1 | Synchronous serial unit interrupt request |
| sync_lvl_i | input | 3 | Programmed level of the synchronous source (0 = disabled) |
| async_req_i | input | 1 | Asynchronous serial unit interrupt request |
| async_lvl_i | input | 3 | Programmed level of the asynchronous source (0 = disabled) |
| vec_base_i | input | 8 | Programmed vector number base |
| arb_id_i | input | 4 | Arbitration ID of this block (0 = block silent) |
| cpu_mask_i | input | 3 | Current CPU interrupt mask level |
| iack_i | input | 1 | Acknowledge cycle in progress |
| iack_lvl_i | input | 3 | Level being acknowledged |
| arb_bus_i | input | 4 | Highest arbitration ID offered by competing modules |
| irq_lvl_o | output | 3 | Registered winning request level |
| irq_o | output | 1 | Request above CPU mask |
| ack_valid_o | output | 1 | Block supplies the vector in this acknowledge |
| vec_o | output | 8 | Vector number |
| vec_off_o | output | 9 | Vector table offset (vector number times two) |

## Verification
The bench targets the equal-level tie between the two sources. A design that broke the tie toward the asynchronous source would return a vector with bit 0 cleared. The bench also drives an arbitration ID equal to the competing one. A design that compared with "greater or equal" would answer and collide on the bus. A mask equal to the request level is tested as well, which catches a non-strict comparison. Other checks cover a zero arbitration ID with both sources pending, a source enabled with a zero level, and the one-cycle request latency. A design with the arbitration gate missing, the level-zero gate missing, or a combinational request path would show a non-zero level where 0 or the old value is expected.

// File: rtl/irq_dual_prio_pkg.sv
package irq_dual_prio_pkg;
  typedef enum logic {
    SRC_ASYNC = 1'b0,
    SRC_SYNC  = 1'b1
  } irq_src_e;
endpackage

// File: rtl/irq_level_pick.sv
module irq_level_pick
  import irq_dual_prio_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int ARB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_req_i,
  input  logic [LVL_W-1:0] sync_lvl_i,
  input  logic             async_req_i,
  input  logic [LVL_W-1:0] async_lvl_i,
  input  logic [ARB_W-1:0] arb_id_i,
  output logic [LVL_W-1:0] win_lvl_o,
  output irq_src_e         win_src_o
);
  logic sync_on, async_on, take_sync;

  always_comb begin
    sync_on   = sync_req_i  && (sync_lvl_i  != '0);
    async_on  = async_req_i && (async_lvl_i != '0);
    // Tie at equal level goes to the synchronous unit
    take_sync = sync_on && (!async_on || (sync_lvl_i >= async_lvl_i));
    win_src_o = take_sync ? SRC_SYNC : SRC_ASYNC;
    if (arb_id_i == '0) begin
      win_lvl_o = '0;
    end else if (take_sync) begin
      win_lvl_o = sync_lvl_i;
    end else if (async_on) begin
      win_lvl_o = async_lvl_i;
    end else begin
      win_lvl_o = '0;
    end
  end

  // R4: equal enabled levels pick the synchronous unit
  p_tie_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req_i && async_req_i && sync_lvl_i != '0 && sync_lvl_i == async_lvl_i)
      |-> (win_src_o == SRC_SYNC));

  // R2: a disabled source never yields a level on its own
  p_lvl_zero_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_req_i && sync_lvl_i == '0) |-> (win_lvl_o == '0));
endmodule

// File: rtl/irq_req_reg.sv
module irq_req_reg
  import irq_dual_prio_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int ARB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] win_lvl_i,
  input  irq_src_e         win_src_i,
  input  logic [ARB_W-1:0] arb_id_i,
  input  logic [LVL_W-1:0] cpu_mask_i,
  output logic [LVL_W-1:0] lvl_q_o,
  output irq_src_e         src_q_o,
  output logic             irq_o
);
  logic [LVL_W-1:0] lvl_d, lvl_q;
  irq_src_e         src_d, src_q;
  logic             upd_en;

  always_comb begin
    lvl_d  = win_lvl_i;
    src_d  = win_src_i;
    upd_en = (lvl_d != lvl_q) || (src_d != src_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      src_q <= SRC_ASYNC;
    end else if (upd_en) begin
      lvl_q <= lvl_d;
      src_q <= src_d;
    end
  end

  assign lvl_q_o = lvl_q;
  assign src_q_o = src_q;
  assign irq_o   = (lvl_q > cpu_mask_i);

  // R6: a zero arbitration ID silences the request on the next edge
  p_arb_zero_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_id_i == '0) |=> (lvl_q == '0));

  // R8: registered level follows the picked level one cycle later
  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lvl_q == $past(win_lvl_i)));
endmodule

// File: rtl/irq_ack_resp.sv
module irq_ack_resp
  import irq_dual_prio_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int ARB_W = 4,
  parameter int VEC_W = 8,
  localparam int OFF_W = VEC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack_i,
  input  logic [LVL_W-1:0] iack_lvl_i,
  input  logic [ARB_W-1:0] arb_id_i,
  input  logic [ARB_W-1:0] arb_bus_i,
  input  logic [VEC_W-1:0] vec_base_i,
  input  logic [LVL_W-1:0] lvl_q_i,
  input  irq_src_e         src_q_i,
  output logic             ack_valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [OFF_W-1:0] vec_off_o
);
  logic             hit;
  logic [VEC_W-1:0] vec_full;

  always_comb begin
    hit         = iack_i && (lvl_q_i != '0) && (iack_lvl_i == lvl_q_i)
                  && (arb_id_i > arb_bus_i);
    vec_full    = vec_base_i;
    vec_full[0] = src_q_i;
    ack_valid_o = hit;
    vec_o       = hit ? vec_full : '0;
    vec_off_o   = {vec_o, 1'b0};
  end

  // R9: answer only for our own non-zero level
  p_ack_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> (iack_lvl_i == lvl_q_i && lvl_q_i != '0));

  // R5: vector LSB names the registered winning source
  p_vec_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> (vec_o[0] == src_q_i));
endmodule

// File: rtl/irq_dual_prio.sv
module irq_dual_prio
  import irq_dual_prio_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int ARB_W = 4,
  parameter int VEC_W = 8,
  localparam int OFF_W = VEC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_req_i,
  input  logic [LVL_W-1:0] sync_lvl_i,
  input  logic             async_req_i,
  input  logic [LVL_W-1:0] async_lvl_i,
  input  logic [VEC_W-1:0] vec_base_i,
  input  logic [ARB_W-1:0] arb_id_i,
  input  logic [LVL_W-1:0] cpu_mask_i,
  input  logic             iack_i,
  input  logic [LVL_W-1:0] iack_lvl_i,
  input  logic [ARB_W-1:0] arb_bus_i,
  output logic [LVL_W-1:0] irq_lvl_o,
  output logic             irq_o,
  output logic             ack_valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [OFF_W-1:0] vec_off_o
);
  logic [LVL_W-1:0] win_lvl, lvl_q;
  irq_src_e         win_src, src_q;

  irq_level_pick #(.LVL_W(LVL_W), .ARB_W(ARB_W)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .sync_req_i(sync_req_i), .sync_lvl_i(sync_lvl_i),
    .async_req_i(async_req_i), .async_lvl_i(async_lvl_i),
    .arb_id_i(arb_id_i),
    .win_lvl_o(win_lvl), .win_src_o(win_src)
  );

  irq_req_reg #(.LVL_W(LVL_W), .ARB_W(ARB_W)) u_reg (
    .clk(clk), .rst_n(rst_n),
    .win_lvl_i(win_lvl), .win_src_i(win_src),
    .arb_id_i(arb_id_i), .cpu_mask_i(cpu_mask_i),
    .lvl_q_o(lvl_q), .src_q_o(src_q), .irq_o(irq_o)
  );

  irq_ack_resp #(.LVL_W(LVL_W), .ARB_W(ARB_W), .VEC_W(VEC_W)) u_ack (
    .clk(clk), .rst_n(rst_n),
    .iack_i(iack_i), .iack_lvl_i(iack_lvl_i),
    .arb_id_i(arb_id_i), .arb_bus_i(arb_bus_i),
    .vec_base_i(vec_base_i),
    .lvl_q_i(lvl_q), .src_q_i(src_q),
    .ack_valid_o(ack_valid_o), .vec_o(vec_o), .vec_off_o(vec_off_o)
  );

  assign irq_lvl_o = lvl_q;

  // R7: strobe only above the CPU mask
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_lvl_o > cpu_mask_i));
endmodule

// File: tb/irq_dual_prio_bench.sv
module irq_dual_prio_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_req, async_req, iack;
  logic [2:0] sync_lvl, async_lvl, cpu_mask, iack_lvl;
  logic [7:0] vec_base;
  logic [3:0] arb_id, arb_bus;
  logic [2:0] irq_lvl;
  logic       irq, ack_valid;
  logic [7:0] vec;
  logic [8:0] vec_off;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  irq_dual_prio u_irq_dual_prio (
    .clk(clk), .rst_n(rst_n),
    .sync_req_i(sync_req), .sync_lvl_i(sync_lvl),
    .async_req_i(async_req), .async_lvl_i(async_lvl),
    .vec_base_i(vec_base), .arb_id_i(arb_id), .cpu_mask_i(cpu_mask),
    .iack_i(iack), .iack_lvl_i(iack_lvl), .arb_bus_i(arb_bus),
    .irq_lvl_o(irq_lvl), .irq_o(irq), .ack_valid_o(ack_valid),
    .vec_o(vec), .vec_off_o(vec_off)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drive at falling edge, let one rising edge register it, sample 1 ns after
  task automatic apply(logic sr, logic [2:0] sl, logic ar, logic [2:0] al);
    @(negedge clk);
    sync_req = sr; sync_lvl = sl; async_req = ar; async_lvl = al;
    @(posedge clk); #1;
  endtask

  task automatic ack(logic [2:0] lvl, logic [3:0] bus);
    @(negedge clk);
    iack = 1'b1; iack_lvl = lvl; arb_bus = bus;
    #1;
  endtask

  task automatic ack_end();
    @(negedge clk);
    iack = 1'b0; iack_lvl = 3'd0; arb_bus = 4'd0;
  endtask

  task automatic t_reset();
    chk("R1 lvl", irq_lvl, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ack", ack_valid, 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    sync_req = 1'b1; sync_lvl = 3'd3;
    #1 chk("R8 before edge", irq_lvl, 0);
    @(posedge clk); #1;
    chk("R8 after edge", irq_lvl, 3);
    apply(1'b0, 3'd3, 1'b0, 3'd0);
    chk("R8 release", irq_lvl, 0);
  endtask

  task automatic t_level_zero();
    apply(1'b1, 3'd0, 1'b0, 3'd6);
    chk("R2 sync lvl0", irq_lvl, 0);
    apply(1'b1, 3'd0, 1'b1, 3'd0);
    chk("R2 both lvl0", irq_lvl, 0);
    apply(1'b1, 3'd0, 1'b1, 3'd2);
    chk("R2 async only", irq_lvl, 2);
  endtask

  task automatic t_higher_wins();
    apply(1'b1, 3'd2, 1'b1, 3'd5);
    chk("R3 async higher", irq_lvl, 5);
    ack(3'd5, 4'd0);
    chk("R5 async ack valid", ack_valid, 1);
    chk("R5 async vec", vec, 8'h40);
    chk("R5 async off", vec_off, 9'h080);
    ack_end();
    apply(1'b1, 3'd6, 1'b1, 3'd5);
    chk("R3 sync higher", irq_lvl, 6);
  endtask

  task automatic t_tie();
    apply(1'b1, 3'd4, 1'b1, 3'd4);
    chk("R4 tie lvl", irq_lvl, 4);
    ack(3'd4, 4'd3);
    chk("R4 tie valid", ack_valid, 1);
    chk("R4 tie vec", vec, 8'h41);
    chk("R5 sync off", vec_off, 9'h082);
    ack_end();
  endtask

  task automatic t_mask();
    apply(1'b1, 3'd4, 1'b0, 3'd0);
    @(negedge clk); cpu_mask = 3'd4; #1;
    chk("R7 equal mask", irq, 0);
    @(negedge clk); cpu_mask = 3'd3; #1;
    chk("R7 below mask", irq, 1);
    @(negedge clk); cpu_mask = 3'd0;
  endtask

  task automatic t_ack_rules();
    apply(1'b0, 3'd0, 1'b1, 3'd3);
    ack(3'd2, 4'd0);
    chk("R9 wrong level", ack_valid, 0);
    chk("R9 wrong level vec", vec, 0);
    ack(3'd3, 4'd9);
    chk("R9 equal id", ack_valid, 0);
    ack(3'd3, 4'd12);
    chk("R9 higher competitor", ack_valid, 0);
    ack(3'd3, 4'd8);
    chk("R9 win", ack_valid, 1);
    ack_end();
  endtask

  task automatic t_arb_zero();
    @(negedge clk); arb_id = 4'd0;
    apply(1'b1, 3'd7, 1'b1, 3'd5);
    chk("R6 lvl", irq_lvl, 0);
    chk("R6 irq", irq, 0);
    ack(3'd7, 4'd0);
    chk("R6 ack", ack_valid, 0);
    ack_end();
    arb_id = 4'd9;
    @(posedge clk); #1;
    chk("R6 restored", irq_lvl, 7);
  endtask

  initial begin
    rst_n = 1'b0;
    sync_req = 0; async_req = 0; sync_lvl = 0; async_lvl = 0;
    vec_base = 8'h41; arb_id = 4'd9; cpu_mask = 0;
    iack = 0; iack_lvl = 0; arb_bus = 0;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_latency();
    t_level_zero();
    t_higher_wins();
    t_tie();
    t_mask();
    t_ack_rules();
    t_arb_zero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule